// File: doc/BRIEF.md
# Recursive Divide-and-Conquer Multiplier

This block multiplies two unsigned operands of `WIDTH` bits each and returns the full product of `2*WIDTH` bits. It splits each operand into an upper and a lower half and forms four half-width partial products from the pairings: upper by upper, upper by lower, lower by upper, and lower by lower. It then merges them by shifting and adding. Each half-width product is built the same way, one level down, until the operands reach the leaf width. At the leaf, a fixed gate network does the multiply. The leaf is either a 2-bit multiplier or a single AND gate.

The merge uses five adders, each half as wide as the current level. Carries pass from the lower-order columns into the higher-order columns. The low quarter of the result is taken from the lower-by-lower product directly, with no adder in its path. The multiply tree is purely combinational. An optional output register, on by default, captures a product whenever `in_valid` is high. The register holds its contents when `in_valid` is low, and its valid flag follows `in_valid` one cycle later.

Top module: `dcm_mult`

## Requirements
- R1: With the output register enabled, `product` equals the unsigned product `op_a * op_b` in all 2*WIDTH bits, one clock after `in_valid` is sampled high. This holds for every operand pair of the default 8-bit width.
- R2: The result equals 2^WIDTH·(upper·upper) + 2^(WIDTH/2)·(upper·lower + lower·upper) + lower·lower. For example, 185 × 39 gives 7215, where the four 8-bit partial products are 22, 77, 18 and 63.
- R3: Bits [WIDTH/2-1:0] of `product` equal the low WIDTH/2 bits of (op_a[WIDTH/2-1:0] × op_b[WIDTH/2-1:0]).
- R4: Cases that exercise every carry path give exact results. These include all-ones by all-ones (255 × 255 = 65025 at 8 bits; 0xFFFE0001 at 16 bits) and the single top bit squared (128 × 128 = 16384).
- R5: An operand of zero gives a product of zero. An operand of one gives the other operand, zero-extended.
- R6: `out_valid` is high in a cycle exactly when `in_valid` was high at the previous clock edge. Back-to-back valid operands produce back-to-back results.
- R7: While `in_valid` is low, `product` keeps its last captured value, whatever is on `op_a` and `op_b`.
- R8: When `rst_n` is low, `out_valid` goes to 0 and `product` goes to 0 at once, without waiting for a clock edge.
- R9: A leaf width of 1 (AND-gate leaves) and a leaf width of 2 (2-bit leaves) give identical products for every operand pair.
- R10: With WIDTH = 16 the block returns the exact 32-bit product for directed and pseudo-random operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are valid; capture their product |
| op_a | input | WIDTH | Multiplicand, unsigned |
| op_b | input | WIDTH | Multiplier, unsigned |
| out_valid | output | 1 | `product` holds a result captured at the previous edge |
| product | output | 2*WIDTH | Full unsigned product |

## Verification
The output register can take a new product in the same edge that ends the display of the previous product. It can also hold a result while the operand inputs change underneath it. The bench provokes the first case with two valid operand pairs on consecutive cycles and judges it by reading the first product, then the second, one cycle apart, with `out_valid` high in both cycles. It provokes the second case by dropping `in_valid` while driving new operands, then confirms that `product` still shows the earlier result and that `out_valid` has fallen.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    // Carries that leave the low and middle columns of one stitch level.
    typedef struct packed {
        logic lo_a;   // low column, first adder
        logic lo_b;   // low column, second adder
        logic mid_a;  // middle column, first adder
        logic mid_b;  // middle column, second adder
    } stitch_carry_t;

    // Leaf variants selectable by parameter.
    localparam int unsigned LEAF_GATE = 1;
    localparam int unsigned LEAF_PAIR = 2;

endpackage

// File: rtl/dcm_add.sv
module dcm_add #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int unsigned SW = W + 1;

    logic [SW-1:0] full;

    always_comb begin
        full = SW'(x) + SW'(y) + SW'(cin);
        sum  = full[W-1:0];
        cout = full[W];
    end
endmodule

// File: rtl/dcm_leaf.sv
module dcm_leaf #(
    parameter int unsigned W = 2
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    generate
        if (W == dcm_pkg::LEAF_GATE) begin : g_gate
            // One-bit product is a single AND.
            always_comb p = {1'b0, a[0] & b[0]};
        end else begin : g_pair
            // Two-bit product from four partial terms.
            logic t00, t01, t10, t11, k;
            always_comb begin
                t00 = a[0] & b[0];
                t01 = a[0] & b[1];
                t10 = a[1] & b[0];
                t11 = a[1] & b[1];
                k   = t01 & t10;
                p[0] = t00;
                p[1] = t01 ^ t10;
                p[2] = t11 ^ k;
                p[3] = t11 & k;
            end
        end
    endgenerate
endmodule

// File: rtl/dcm_stitch.sv
module dcm_stitch #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]   pl,
    input  logic [W-1:0]   pm1,
    input  logic [W-1:0]   pm2,
    input  logic [W-1:0]   ph,
    output logic [2*W-1:0] prod
);
    localparam int unsigned H = W / 2;

    dcm_pkg::stitch_carry_t cy;
    logic [H-1:0] s_lo_a, s_lo_b, s_mid_a, s_mid_b, s_top;

    // Low column: PL upper half + PM1 lower half + PM2 lower half.
    dcm_add #(.W(H)) u_lo_a (
        .x(pl[W-1:H]), .y(pm1[H-1:0]), .cin(1'b0),
        .sum(s_lo_a), .cout(cy.lo_a)
    );
    dcm_add #(.W(H)) u_lo_b (
        .x(s_lo_a), .y(pm2[H-1:0]), .cin(1'b0),
        .sum(s_lo_b), .cout(cy.lo_b)
    );

    // Middle column: PM1 upper + PM2 upper + PH lower, plus low-column carries.
    dcm_add #(.W(H)) u_mid_a (
        .x(pm1[W-1:H]), .y(pm2[W-1:H]), .cin(cy.lo_a),
        .sum(s_mid_a), .cout(cy.mid_a)
    );
    dcm_add #(.W(H)) u_mid_b (
        .x(s_mid_a), .y(ph[H-1:0]), .cin(cy.lo_b),
        .sum(s_mid_b), .cout(cy.mid_b)
    );

    // Top column: PH upper half absorbs both middle carries; the true product
    // fits in 2W bits, so this adder has no carry out.
    always_comb begin
        s_top = ph[W-1:H] + H'(cy.mid_a) + H'(cy.mid_b);
        prod  = {s_top, s_mid_b, s_lo_b, pl[H-1:0]};
    end
endmodule

// File: rtl/dcm_core.sv
module dcm_core #(
    parameter int unsigned W      = 8,
    parameter int unsigned LEAF_W = 2
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    generate
        if (W <= LEAF_W) begin : g_leaf
            dcm_leaf #(.W(W)) u_leaf (.a(a), .b(b), .p(prod));
        end else begin : g_split
            localparam int unsigned H = W / 2;

            logic [W-1:0] p_ll, p_hl, p_lh, p_hh;

            dcm_core #(.W(H), .LEAF_W(LEAF_W)) u_ll (
                .a(a[H-1:0]), .b(b[H-1:0]), .prod(p_ll));
            dcm_core #(.W(H), .LEAF_W(LEAF_W)) u_hl (
                .a(a[W-1:H]), .b(b[H-1:0]), .prod(p_hl));
            dcm_core #(.W(H), .LEAF_W(LEAF_W)) u_lh (
                .a(a[H-1:0]), .b(b[W-1:H]), .prod(p_lh));
            dcm_core #(.W(H), .LEAF_W(LEAF_W)) u_hh (
                .a(a[W-1:H]), .b(b[W-1:H]), .prod(p_hh));

            dcm_stitch #(.W(W)) u_stitch (
                .pl(p_ll), .pm1(p_hl), .pm2(p_lh), .ph(p_hh), .prod(prod));
        end
    endgenerate
endmodule

// File: rtl/dcm_mult.sv
module dcm_mult #(
    parameter int unsigned WIDTH      = 8,
    parameter int unsigned LEAF_WIDTH = 2,
    parameter bit          REG_OUT    = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [WIDTH-1:0]     op_a,
    input  logic [WIDTH-1:0]     op_b,
    output logic                 out_valid,
    output logic [2*WIDTH-1:0]   product
);
    localparam int unsigned PW = 2 * WIDTH;

    typedef struct packed {
        logic          vld;
        logic [PW-1:0] prod;
    } out_stage_t;

    logic [PW-1:0] tree_prod;
    out_stage_t    stage_d, stage_q;

    dcm_core #(.W(WIDTH), .LEAF_W(LEAF_WIDTH)) u_tree (
        .a(op_a), .b(op_b), .prod(tree_prod));

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.prod = tree_prod;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            always_comb begin
                out_valid = stage_q.vld;
                product   = stage_q.prod;
            end
        end else begin : g_comb
            always_comb begin
                out_valid = in_valid;
                product   = tree_prod;
            end
        end
    endgenerate
endmodule

// File: rtl/dcm_mult_chk.sv
module dcm_mult_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [WIDTH-1:0]   op_a,
    input logic [WIDTH-1:0]   op_b,
    input logic               out_valid,
    input logic [2*WIDTH-1:0] product
);
    localparam int unsigned PW = 2 * WIDTH;
    localparam int unsigned H  = WIDTH / 2;

    // R1: registered product matches the arithmetic product of the sampled operands
    a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (product == (PW'($past(op_a)) * PW'($past(op_b)))));

    // R3: low quarter of the result comes from the low-by-low product
    a_r3_low_quarter: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (product[H-1:0] ==
                      H'($past(op_a[H-1:0]) * $past(op_b[H-1:0]))));

    // R5: a zero operand forces a zero result
    a_r5_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((op_a == '0) || (op_b == '0))) |=> (product == '0));

    // R6: valid flag follows the input valid by one edge
    a_r6_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r6_valid_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7: no capture while the input valid is low
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(product));
endmodule

bind dcm_mult dcm_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
    .op_b(op_b), .out_valid(out_valid), .product(product)
);

// File: tb/tb_dcm_mult.sv
module tb_dcm_mult;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [7:0]  a8, b8;
    logic [15:0] a16, b16;
    logic        v8, v8g, v16;
    logic [15:0] p8, p8g;
    logic [31:0] p16;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    dcm_mult #(.WIDTH(8), .LEAF_WIDTH(2)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(a8), .op_b(b8),
        .out_valid(v8), .product(p8));
    dcm_mult #(.WIDTH(8), .LEAF_WIDTH(1)) dut_gate (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(a8), .op_b(b8),
        .out_valid(v8g), .product(p8g));
    dcm_mult #(.WIDTH(16), .LEAF_WIDTH(2)) dut_w16 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(a16), .op_b(b16),
        .out_valid(v16), .product(p16));

    // {op_a, op_b, expected product} for the 8-bit instance (R2, R4, R5)
    localparam logic [31:0] TBL8 [10] = '{
        {8'd185, 8'd39,  16'd7215},
        {8'd255, 8'd255, 16'd65025},
        {8'd128, 8'd128, 16'd16384},
        {8'd0,   8'd201, 16'd0},
        {8'd173, 8'd0,   16'd0},
        {8'd1,   8'd254, 16'd254},
        {8'd99,  8'd1,   16'd99},
        {8'd15,  8'd240, 16'd3600},
        {8'd240, 8'd15,  16'd3600},
        {8'd17,  8'd17,  16'd289}
    };
    // {op_a, op_b} and expected product for the 16-bit instance (R4, R10)
    localparam logic [31:0] OPS16 [4] = '{
        {16'hFFFF, 16'hFFFF}, {16'hFF00, 16'h00FF},
        {16'h8000, 16'h0002}, {16'h0000, 16'h04D2}
    };
    localparam logic [31:0] EXP16 [4] = '{
        32'hFFFE0001, 32'h00FE0100, 32'h00010000, 32'h00000000
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] x, input logic [7:0] y,
                        input logic [15:0] x16, input logic [15:0] y16);
        @(negedge clk);
        in_valid = v; a8 = x; b8 = y; a16 = x16; b16 = y16;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b1;
        a8 = 8'hFF; b8 = 8'hFF; a16 = 16'hFFFF; b16 = 16'hFFFF;
        repeat (3) @(posedge clk);
        #1;
        // R8: held in reset despite valid operands
        chk("R8 reset valid", 32'(v8), 32'd0);
        chk("R8 reset product", 32'(p8), 32'd0);
        chk("R8 reset product w16", p16, 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // Directed table: R2 worked example, R4 carry paths, R5 zero/one, R3 low bits
        for (int i = 0; i < 10; i++) begin
            step(1'b1, TBL8[i][31:24], TBL8[i][23:16], OPS16[i % 4][31:16], OPS16[i % 4][15:0]);
            chk("R2/R4/R5 table product", 32'(p8), 32'(TBL8[i][15:0]));
            chk("R3 low quarter", 32'(p8[3:0]),
                32'((TBL8[i][27:24] * TBL8[i][19:16]) & 8'h0F));
            chk("R10/R4 table w16", p16, EXP16[i % 4]);
        end

        // R1 exhaustive against the built-in multiply; R9 leaf variants agree
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                step(1'b1, 8'(x), 8'(y), 16'(x), 16'(y));
                chk("R1 exhaustive", 32'(p8), 32'(x * y));
                chk("R9 gate leaves", 32'(p8g), 32'(x * y));
            end
        end

        // R10: pseudo-random 16-bit operands
        for (int k = 0; k < 2000; k++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = 16'($urandom);
            step(1'b1, 8'd0, 8'd0, ra, rb);
            chk("R10 random w16", p16, 32'(ra) * 32'(rb));
        end

        // R6: back-to-back results then a bubble
        step(1'b1, 8'd10, 8'd10, 16'd0, 16'd0);
        chk("R6 first result", 32'(p8), 32'd100);
        chk("R6 first valid", 32'(v8), 32'd1);
        step(1'b1, 8'd20, 8'd20, 16'd0, 16'd0);
        chk("R6 second result", 32'(p8), 32'd400);
        chk("R6 second valid", 32'(v8), 32'd1);

        // R7: operands change with valid low, product holds
        step(1'b0, 8'd7, 8'd7, 16'd9, 16'd9);
        chk("R7 hold product", 32'(p8), 32'd400);
        chk("R6 valid drops", 32'(v8), 32'd0);
        step(1'b0, 8'd255, 8'd3, 16'd9, 16'd9);
        chk("R7 hold product again", 32'(p8), 32'd400);

        // R8: asynchronous reset mid-run
        step(1'b1, 8'd200, 8'd3, 16'd0, 16'd0);
        chk("R1 before reset", 32'(p8), 32'd600);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R8 async clear product", 32'(p8), 32'd0);
        chk("R8 async clear valid", 32'(v8), 32'd0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule